// File: doc/BRIEF.md
# Convolution Layer Sequencer

This controller steps one convolution layer through a small accelerator. A start pulse latches the function bits (zero padding, bias, 2x2 max pooling) and three loop limits: input channels, three-row bands of the feature map, and weight blocks. From then on the controller is the only thing that tells the surrounding units when to work.

It drives five units: weight loader, bias loader, feature-map loader, 3x3 convolution engine and result writer. Each unit gets a one-cycle enable pulse and answers with a one-cycle done pulse. The loop order is fixed. It loads a weight block, then a bias block if bias is on. For every band it loads and convolves each input channel in turn. It saves a result, then moves to the next band or the next weight block. With pooling on, every band is swept over all channels twice before the result is saved.

The controller also holds the running maximum of the pooling window. Pooled sample pairs arrive on a side input. It keeps the larger of each pair and compares that against the stored value. The padding flag it hands to the feature-map loader stays fixed for the whole layer.

Top module: `conv_layer_seq`

## Requirements
- R1: During and right after reset, all five enables and `layer_done_o` are low and `pool_max_o` is 16'h8000, the most negative value.
- R2: A start in idle latches every configuration input and is followed, in the next cycle, by a weight-load enable. Start pulses and configuration changes while a layer runs have no effect on that layer.
- R3: After the weight-load done, a bias-load enable follows only if the latched bias bit is 1. Otherwise the feature-map load comes next.
- R4: Each band handles input channels 0 to `cfg_ch_i` in order. Each channel gets a feature-map load followed by a convolve. A field value k therefore means k+1 channels.
- R5: With pooling off, the convolve done of the last channel leads to a result save. With pooling on, the channel sweep runs twice and then the result save follows.
- R6: After the result-save done, the next band starts with channel 0 at a feature-map load. After the last band (`cfg_band_i`+1 bands), the next weight block starts at a weight load. After the last weight block (`cfg_wblk_i`+1 blocks), the layer ends.
- R7: Every enable lasts one cycle and at most one enable is high at a time. The controller waits in a state for as long as that unit's done takes. Done pulses from any other unit are ignored.
- R8: `layer_done_o` is a one-cycle pulse in the cycle after the final result-save done is accepted.
- R9: While a pooling layer runs, each `pool_valid_i` takes the larger signed value of `pool_a_i` and `pool_b_i` into the maximum. The maximum returns to 16'h8000 at layer start and after each result-save done. It does not change when pooling is off or no layer is running.
- R10: `fmap_pad_o` equals the padding bit latched at the start of the layer, and it holds there until the next layer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a layer (taken only in idle) |
| cfg_pad_i | input | 1 | Zero-padding function bit |
| cfg_bias_i | input | 1 | Bias function bit |
| cfg_pool_i | input | 1 | Max-pooling function bit |
| cfg_ch_i | input | CH_W | Input channels minus one |
| cfg_band_i | input | BAND_W | Three-row bands minus one |
| cfg_wblk_i | input | WB_W | Weight blocks minus one |
| wgt_en_o | output | 1 | Weight load enable pulse |
| wgt_done_i | input | 1 | Weight load done pulse |
| bias_en_o | output | 1 | Bias load enable pulse |
| bias_done_i | input | 1 | Bias load done pulse |
| fmap_en_o | output | 1 | Feature-map load enable pulse |
| fmap_done_i | input | 1 | Feature-map load done pulse |
| fmap_pad_o | output | 1 | Latched padding flag for the feature-map loader |
| conv_en_o | output | 1 | Convolve enable pulse |
| conv_done_i | input | 1 | Convolve done pulse |
| res_en_o | output | 1 | Result save enable pulse |
| res_done_i | input | 1 | Result save done pulse |
| pool_valid_i | input | 1 | Pooling pair valid |
| pool_a_i | input | DW | Pooling sample A, signed |
| pool_b_i | input | DW | Pooling sample B, signed |
| pool_max_o | output | DW | Running pooling maximum, signed |
| layer_done_o | output | 1 | Layer complete pulse |

## Verification
A wrong state or counter value shows up at the very next enable. The pulse either names the wrong unit or comes one load too early or too late, so the logged enable order is compared with the order built from the requirements for every layer. A bad pooling register or window reset is seen at the next result-save enable, where the maximum is compared with the value the bench tracked. A stray start or a configuration change taken mid-layer would add or drop enables before `layer_done_o`. A padding flag that is not held is caught at each feature-map load.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int unsigned NUM_UNITS = 5;
  localparam int unsigned U_WGT  = 0;
  localparam int unsigned U_BIAS = 1;
  localparam int unsigned U_FMAP = 2;
  localparam int unsigned U_CONV = 3;
  localparam int unsigned U_RES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LWB  = 3'd1,
    ST_LBB  = 3'd2,
    ST_LFB  = 3'd3,
    ST_CONV = 3'd4,
    ST_SRB  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic pad;
    logic bias;
    logic pool;
  } func_bits_t;

  function automatic seq_state_e unit_state(int unsigned u);
    case (u)
      U_WGT:   return ST_LWB;
      U_BIAS:  return ST_LBB;
      U_FMAP:  return ST_LFB;
      U_CONV:  return ST_CONV;
      default: return ST_SRB;
    endcase
  endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pool_max_unit.sv
module pool_max_unit #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] max_o
);
  localparam logic [DW-1:0] MIN_VAL = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] pair_max;
  logic [DW-1:0] max_q;

  // first stage: larger of the pair
  assign pair_max = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
  assign max_o    = max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= MIN_VAL;
    end else if (init_i) begin
      max_q <= MIN_VAL;
    end else if (en_i && valid_i && ($signed(pair_max) > $signed(max_q))) begin
      max_q <= pair_max;
    end
  end
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 bias_on_i,
  input  logic [NUM_UNITS-1:0] done_i,
  input  logic                 ch_last_i,
  input  logic                 pass_last_i,
  input  logic                 band_last_i,
  input  logic                 wb_last_i,
  output logic [NUM_UNITS-1:0] en_o,
  output logic                 start_acc_o,
  output logic                 conv_step_o,
  output logic                 sweep_step_o,
  output logic                 res_step_o,
  output logic                 wb_step_o,
  output logic                 busy_o,
  output logic                 layer_done_o
);
  seq_state_e state_q, state_d;
  logic entry_q;
  logic layer_end;
  logic layer_done_q;
  logic [NUM_UNITS-1:0] acc;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign en_o[u] = entry_q && (state_q == unit_state(u));
    assign acc[u]  = done_i[u] && (state_q == unit_state(u));
  end

  always_comb begin
    state_d   = state_q;
    layer_end = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LWB;
      ST_LWB:  if (acc[U_WGT]) state_d = bias_on_i ? ST_LBB : ST_LFB;
      ST_LBB:  if (acc[U_BIAS]) state_d = ST_LFB;
      ST_LFB:  if (acc[U_FMAP]) state_d = ST_CONV;
      ST_CONV: if (acc[U_CONV]) state_d = (ch_last_i && pass_last_i) ? ST_SRB : ST_LFB;
      ST_SRB: begin
        if (acc[U_RES]) begin
          if (!band_last_i)    state_d = ST_LFB;
          else if (!wb_last_i) state_d = ST_LWB;
          else begin
            state_d   = ST_IDLE;
            layer_end = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign start_acc_o  = (state_q == ST_IDLE) && start_i;
  assign conv_step_o  = acc[U_CONV];
  assign sweep_step_o = acc[U_CONV] && ch_last_i;
  assign res_step_o   = acc[U_RES];
  assign wb_step_o    = acc[U_RES] && band_last_i;
  assign busy_o       = (state_q != ST_IDLE);
  assign layer_done_o = layer_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      entry_q      <= 1'b0;
      layer_done_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      entry_q      <= (state_d != state_q) && (state_d != ST_IDLE);
      layer_done_q <= layer_end;
    end
  end
endmodule

// File: rtl/conv_layer_seq.sv
module conv_layer_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned CH_W   = 4,
  parameter int unsigned BAND_W = 4,
  parameter int unsigned WB_W   = 4,
  parameter int unsigned DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_pad_i,
  input  logic              cfg_bias_i,
  input  logic              cfg_pool_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [BAND_W-1:0] cfg_band_i,
  input  logic [WB_W-1:0]   cfg_wblk_i,
  output logic              wgt_en_o,
  input  logic              wgt_done_i,
  output logic              bias_en_o,
  input  logic              bias_done_i,
  output logic              fmap_en_o,
  input  logic              fmap_done_i,
  output logic              fmap_pad_o,
  output logic              conv_en_o,
  input  logic              conv_done_i,
  output logic              res_en_o,
  input  logic              res_done_i,
  input  logic              pool_valid_i,
  input  logic [DW-1:0]     pool_a_i,
  input  logic [DW-1:0]     pool_b_i,
  output logic [DW-1:0]     pool_max_o,
  output logic              layer_done_o
);
  func_bits_t          func_q;
  logic                func_bias_q;
  logic [CH_W-1:0]     ch_lim_q;
  logic [BAND_W-1:0]   band_lim_q;
  logic [WB_W-1:0]     wb_lim_q;

  logic [NUM_UNITS-1:0] en_vec;
  logic [NUM_UNITS-1:0] done_vec;
  logic start_acc, conv_step, sweep_step, res_step, wb_step, busy;
  logic ch_last, pass_last, band_last, wb_last;

  assign done_vec = {res_done_i, conv_done_i, fmap_done_i, bias_done_i, wgt_done_i};
  assign {res_en_o, conv_en_o, fmap_en_o, bias_en_o, wgt_en_o} = en_vec;
  assign func_bias_q = func_q.bias;
  assign fmap_pad_o  = func_q.pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q     <= '0;
      ch_lim_q   <= '0;
      band_lim_q <= '0;
      wb_lim_q   <= '0;
    end else if (start_acc) begin
      func_q     <= '{pad: cfg_pad_i, bias: cfg_bias_i, pool: cfg_pool_i};
      ch_lim_q   <= cfg_ch_i;
      band_lim_q <= cfg_band_i;
      wb_lim_q   <= cfg_wblk_i;
    end
  end

  conv_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .bias_on_i    (func_q.bias),
    .done_i       (done_vec),
    .ch_last_i    (ch_last),
    .pass_last_i  (pass_last),
    .band_last_i  (band_last),
    .wb_last_i    (wb_last),
    .en_o         (en_vec),
    .start_acc_o  (start_acc),
    .conv_step_o  (conv_step),
    .sweep_step_o (sweep_step),
    .res_step_o   (res_step),
    .wb_step_o    (wb_step),
    .busy_o       (busy),
    .layer_done_o (layer_done_o)
  );

  seq_counter #(.W(CH_W)) u_ch_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_acc), .inc_i(conv_step),
    .limit_i(ch_lim_q), .last_o(ch_last)
  );

  // pooling needs two channel sweeps per band
  seq_counter #(.W(1)) u_pass_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_acc), .inc_i(sweep_step),
    .limit_i(func_q.pool), .last_o(pass_last)
  );

  seq_counter #(.W(BAND_W)) u_band_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_acc), .inc_i(res_step),
    .limit_i(band_lim_q), .last_o(band_last)
  );

  seq_counter #(.W(WB_W)) u_wb_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_acc), .inc_i(wb_step),
    .limit_i(wb_lim_q), .last_o(wb_last)
  );

  pool_max_unit #(.DW(DW)) u_pool (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (start_acc | res_step),
    .en_i    (func_q.pool & busy),
    .valid_i (pool_valid_i),
    .a_i     (pool_a_i),
    .b_i     (pool_b_i),
    .max_o   (pool_max_o)
  );
endmodule

// File: rtl/conv_layer_seq_chk.sv
module conv_layer_seq_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    en_vec_i,
  input logic          bias_on_i,
  input logic          fmap_en_i,
  input logic          fmap_pad_i,
  input logic          layer_done_i,
  input logic          res_done_i,
  input logic          start_i,
  input logic [DW-1:0] pool_max_i
);
  AST_EN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_vec_i)); // R7

  AST_EN_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_vec_i) |=> !(|en_vec_i)); // R7

  AST_BIAS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_vec_i[1] |-> bias_on_i); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    layer_done_i |=> !layer_done_i); // R8

  AST_POOL_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_done_i && !start_i) |=> ($signed(pool_max_i) >= $signed($past(pool_max_i)))); // R9

  AST_PAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmap_en_i |-> $stable(fmap_pad_i)); // R10
endmodule

bind conv_layer_seq conv_layer_seq_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_vec_i     ({res_en_o, conv_en_o, fmap_en_o, bias_en_o, wgt_en_o}),
  .bias_on_i    (func_bias_q),
  .fmap_en_i    (fmap_en_o),
  .fmap_pad_i   (fmap_pad_o),
  .layer_done_i (layer_done_o),
  .res_done_i   (res_done_i),
  .start_i      (start_i),
  .pool_max_i   (pool_max_o)
);

// File: tb/conv_layer_seq_bench.sv
module conv_layer_seq_bench;
  localparam int DW = 16;
  localparam logic [DW-1:0] MIN_VAL = 16'h8000;

  typedef struct packed {
    logic       pad;
    logic       bias;
    logic       pool;
    logic [3:0] ch;
    logic [3:0] band;
    logic [3:0] wb;
  } layer_vec_t;

  localparam int NVEC = 6;
  localparam layer_vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 4'd2, 4'd1, 4'd0},
    '{1'b0, 1'b1, 1'b1, 4'd1, 4'd1, 4'd1},
    '{1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd1},
    '{1'b1, 1'b1, 1'b0, 4'd2, 4'd0, 4'd1},
    '{1'b0, 1'b0, 1'b1, 4'd2, 4'd1, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_pad = 1'b0, cfg_bias = 1'b0, cfg_pool = 1'b0;
  logic [3:0] cfg_ch = '0, cfg_band = '0, cfg_wb = '0;
  logic wgt_en, bias_en, fmap_en, conv_en, res_en, fmap_pad, layer_done;
  logic [4:0] done_v = '0;
  logic pool_valid = 1'b0;
  logic [DW-1:0] pool_a = '0, pool_b = '0, pool_max;

  always #5 clk = ~clk;

  conv_layer_seq u_conv_layer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_pad_i(cfg_pad), .cfg_bias_i(cfg_bias), .cfg_pool_i(cfg_pool),
    .cfg_ch_i(cfg_ch), .cfg_band_i(cfg_band), .cfg_wblk_i(cfg_wb),
    .wgt_en_o(wgt_en), .wgt_done_i(done_v[0]),
    .bias_en_o(bias_en), .bias_done_i(done_v[1]),
    .fmap_en_o(fmap_en), .fmap_done_i(done_v[2]), .fmap_pad_o(fmap_pad),
    .conv_en_o(conv_en), .conv_done_i(done_v[3]),
    .res_en_o(res_en), .res_done_i(done_v[4]),
    .pool_valid_i(pool_valid), .pool_a_i(pool_a), .pool_b_i(pool_b),
    .pool_max_o(pool_max), .layer_done_o(layer_done)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responders and monitor
  int lat [5] = '{2, 1, 3, 2, 1};
  int cnt [5] = '{0, 0, 0, 0, 0};
  int log_q [128];
  int log_n = 0;
  int done_seen = 0;
  bit cur_pad = 0, cur_pool = 0;
  logic signed [DW-1:0] exp_max = MIN_VAL;
  logic [31:0] lcg = 32'h1234_5678;
  bit poke = 0;

  always @(negedge clk) begin
    logic [4:0] en_v;
    logic prev_res;
    logic signed [DW-1:0] a, b;
    en_v = {res_en, conv_en, fmap_en, bias_en, wgt_en};
    prev_res = done_v[4];
    for (int u = 0; u < 5; u++) begin
      if (cnt[u] > 0) begin
        cnt[u]--;
        done_v[u] = (cnt[u] == 0);
      end else begin
        done_v[u] = 1'b0;
      end
      if (en_v[u]) cnt[u] = lat[u];
    end
    pool_valid = 1'b0;
    if (poke) begin
      pool_valid = 1'b1;
      pool_a = 16'h7000;
      pool_b = 16'h6000;
      poke = 0;
    end
    for (int u = 0; u < 5; u++) begin
      if (en_v[u] && log_n < 128) begin
        log_q[log_n] = u + 1;
        log_n++;
      end
    end
    if (fmap_en) check(fmap_pad == cur_pad, "R10 pad flag", int'(fmap_pad), int'(cur_pad));
    if (conv_en) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a = lcg[30:15];
      lcg = lcg * 32'd1103515245 + 32'd12345;
      b = lcg[30:15];
      pool_a = a;
      pool_b = b;
      pool_valid = 1'b1;
      if (cur_pool) begin
        if (a > exp_max) exp_max = a;
        if (b > exp_max) exp_max = b;
      end
    end
    if (res_en) begin
      check(pool_max == exp_max, "R9 pool max at save", int'(pool_max), int'(exp_max));
      exp_max = MIN_VAL;
    end
    if (layer_done) begin
      done_seen++;
      check(prev_res == 1'b1, "R8 done follows final save", int'(prev_res), 1);
    end
  end

  task automatic run_layer(input int idx, input bit mid_start, input string tag);
    layer_vec_t v;
    int exp_seq [128];
    int exp_n;
    int mism;
    v = VECS[idx];
    exp_n = 0;
    for (int w = 0; w <= int'(v.wb); w++) begin
      exp_seq[exp_n++] = 1;
      if (v.bias) exp_seq[exp_n++] = 2;
      for (int bd = 0; bd <= int'(v.band); bd++) begin
        for (int p = 0; p < (v.pool ? 2 : 1); p++) begin
          for (int c = 0; c <= int'(v.ch); c++) begin
            exp_seq[exp_n++] = 3;
            exp_seq[exp_n++] = 4;
          end
        end
        exp_seq[exp_n++] = 5;
      end
    end
    @(negedge clk);
    cur_pad = v.pad;
    cur_pool = v.pool;
    exp_max = MIN_VAL;
    log_n = 0;
    done_seen = 0;
    cfg_pad = v.pad; cfg_bias = v.bias; cfg_pool = v.pool;
    cfg_ch = v.ch; cfg_band = v.band; cfg_wb = v.wb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_pad = ~v.pad; cfg_bias = ~v.bias; cfg_pool = ~v.pool;
    cfg_ch = ~v.ch; cfg_band = ~v.band; cfg_wb = ~v.wb;
    if (mid_start) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_seen == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(log_n == exp_n, {tag, " enable count"}, log_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < log_n; i++) if (log_q[i] != exp_seq[i]) mism++;
    check(mism == 0, {tag, " enable order"}, mism, 0);
    check(done_seen == 1, "R8 single layer done", done_seen, 1);
    check(pool_max == MIN_VAL, "R9 pool max cleared after layer", int'(pool_max), int'(MIN_VAL));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({wgt_en, bias_en, fmap_en, conv_en, res_en, layer_done} == 6'b0, "R1 outputs in reset",
          int'({wgt_en, bias_en, fmap_en, conv_en, res_en, layer_done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({wgt_en, bias_en, fmap_en, conv_en, res_en, layer_done} == 6'b0, "R1 outputs after reset",
          int'({wgt_en, bias_en, fmap_en, conv_en, res_en, layer_done}), 0);
    check(pool_max == MIN_VAL, "R1 pool max reset", int'(pool_max), int'(MIN_VAL));

    for (int i = 0; i < NVEC; i++) begin
      if (i == 3) lat[0] = 25;
      run_layer(i, i == 1, i == 1 ? "R2 R3 R4 R6" : (i == 3 ? "R7 R5" : "R3 R4 R5 R6"));
      lat[0] = 2;
    end

    // pooling input in idle after a pooling layer must not move the maximum
    @(negedge clk);
    poke = 1;
    repeat (3) @(negedge clk);
    check(pool_max == MIN_VAL, "R9 pool input ignored in idle", int'(pool_max), int'(MIN_VAL));

    // done pulse in idle from a unit is ignored: no enable appears
    log_n = 0;
    done_v[0] = 1'b1;
    repeat (4) @(negedge clk);
    check(log_n == 0, "R7 stray done ignored", log_n, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule